// File: doc/BRIEF.md
# SPI Flash Status Register Emulator

This block holds the status word that an emulated SPI NOR flash shows to its host. The word is 24 bits wide and is built from three status bytes. Bit 0 is the busy flag and bit 1 is the write-enable latch. A serializer in front of the block turns host traffic into bytes and tells the block three things: when chip-select is active, the opcode byte of each transaction, and whether the command-information lookup marked that command as busy-setting. In the other direction, the block returns status bytes as a valid/ready stream. The serializer pulls one byte per beat. If it holds `rd_ready_i` low, the byte on `rd_data_o` stays frozen until the beat is taken.

A command can change the busy flag or the write-enable latch, but the change is held pending until the clock edge that first sees chip-select inactive after the transaction. The status word never moves in the middle of a transaction. The opcodes that set and clear the latch are configuration inputs, and each has its own enable. Software has its own controls:
- read the word;
- overwrite the whole word;
- clear busy and the latch together;
- discard pending command-caused updates.

When a software action and a command commit land on the same edge, the command's update is applied on top of the software action.

Opcode intake follows a simple rule. `op_ready_o` is high only while chip-select is active and no opcode has yet been taken in the current transaction. The first beat where `op_valid_i` and `op_ready_o` are both high fixes the opcode for the whole transaction.

Top module: `flash_status_emu`

## Requirements
- R1: After reset, `status_o` is 0 and both `op_ready_o` and `rd_valid_o` are low.
- R2: `op_ready_o` is high only while `cs_active_i` is high and no opcode has been accepted in the current transaction. It is low in the cycle after an accepted opcode.
- R3: An opcode equal to `wren_op_i` while `wren_en_i` is high sets bit 1 of `status_o` at the edge where `cs_active_i` is first seen low. With `wren_en_i` low, the same opcode leaves the status unchanged.
- R4: An opcode equal to `wrdi_op_i` while `wrdi_en_i` is high clears bit 1 at the end of the transaction. If the opcode matches both enabled opcodes, the set wins.
- R5: An opcode accepted with `op_busy_i` high sets bit 0 at the end of the transaction.
- R6: While chip-select stays active, `status_o` changes only through software inputs, never through the current command.
- R7: Opcodes 0x05, 0x35 and 0x15 raise `rd_valid_o` for the rest of the transaction. They return status bits [7:0], [15:8] and [23:16] respectively, and the same byte repeats on every beat. Any other opcode leaves `rd_valid_o` low.
- R8: While `rd_valid_o` is high and `rd_ready_i` is low, `rd_data_o` holds its value, even if software changes the status word.
- R9: A pulse on `sw_wr_i` loads all 24 bits of `sw_wdata_i` into `status_o` at the next edge.
- R10: A pulse on `sw_clr_busy_i` clears bits 0 and 1 at the next edge and leaves the other bits unchanged.
- R11: A pulse on `sw_clr_req_i` during a transaction, or on its closing edge, discards that transaction's pending busy and latch updates.
- R12: On an edge where software writes or clears and a transaction ends, the command's busy set and latch set/clear are applied after the software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_active_i | input | 1 | Chip-select active, synchronized, high during a transaction |
| op_valid_i | input | 1 | Opcode byte valid |
| op_ready_o | output | 1 | Opcode can be accepted |
| op_i | input | 8 | Opcode byte |
| op_busy_i | input | 1 | Busy-setting attribute of the presented command |
| wren_en_i | input | 1 | Enable for the latch-set opcode |
| wren_op_i | input | 8 | Latch-set opcode |
| wrdi_en_i | input | 1 | Enable for the latch-clear opcode |
| wrdi_op_i | input | 8 | Latch-clear opcode |
| rd_valid_o | output | 1 | Status byte available to the serializer |
| rd_ready_i | input | 1 | Serializer takes the byte this cycle |
| rd_data_o | output | 8 | Status byte being returned |
| sw_wr_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 24 | Software write value |
| sw_clr_busy_i | input | 1 | Software clear of busy and write-enable latch |
| sw_clr_req_i | input | 1 | Software discard of pending command updates |
| status_o | output | 24 | Current status word |

## Verification
A wrong pending flag shows up on `status_o` one edge after chip-select drops. A read-select error shows up in the first cycle after the opcode is accepted, as the wrong byte on `rd_data_o`, and it repeats on every beat. Errors in the stall register only appear when a software write lands during back-pressure, so the bench forces that case: the held byte is checked while stalled and the new byte is checked the cycle after release. Collision ordering only shows when software and a commit share one edge, so directed and random transactions both drive software strobes on the closing edge.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int unsigned BUSY_BIT = 0;
  localparam int unsigned WEL_BIT  = 1;

  typedef struct packed {
    logic wel_set;
    logic wel_clr;
    logic busy_set;
  } fse_upd_t;
endpackage

// File: rtl/fse_cmd_capture.sv
module fse_cmd_capture
  import fse_pkg::*;
#(
  parameter int unsigned NB   = 3,
  parameter int unsigned OPW  = 8,
  parameter int unsigned SELW = 2,
  parameter logic [NB*OPW-1:0] RD_OPS = 24'h153505
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_active_i,
  input  logic            op_valid_i,
  output logic            op_ready_o,
  input  logic [OPW-1:0]  op_i,
  input  logic            busy_attr_i,
  input  logic            wren_en_i,
  input  logic [OPW-1:0]  wren_op_i,
  input  logic            wrdi_en_i,
  input  logic [OPW-1:0]  wrdi_op_i,
  input  logic            clr_req_i,
  output logic            commit_o,
  output fse_upd_t        upd_o,
  output logic            rd_active_o,
  output logic [SELW-1:0] rd_sel_o
);
  logic cs_q, got_q, op_fire, end_evt, hit_any;
  logic [NB-1:0]   rd_hit;
  logic [SELW-1:0] hit_idx;
  fse_upd_t pend_q, new_upd;

  assign op_ready_o = cs_active_i & ~got_q;
  assign op_fire    = op_valid_i & op_ready_o;
  assign end_evt    = cs_q & ~cs_active_i;

  for (genvar g = 0; g < NB; g++) begin : g_rdmatch
    assign rd_hit[g] = (op_i == RD_OPS[g*OPW +: OPW]);
  end

  always_comb begin
    hit_any = |rd_hit;
    hit_idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (rd_hit[i]) hit_idx = SELW'(i);
    end
  end

  always_comb begin
    new_upd.wel_set  = wren_en_i & (op_i == wren_op_i);
    new_upd.wel_clr  = wrdi_en_i & (op_i == wrdi_op_i) & ~new_upd.wel_set;
    new_upd.busy_set = busy_attr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q        <= 1'b0;
      got_q       <= 1'b0;
      pend_q      <= '0;
      rd_active_o <= 1'b0;
      rd_sel_o    <= '0;
    end else begin
      cs_q <= cs_active_i;
      if (end_evt) begin
        got_q       <= 1'b0;
        pend_q      <= '0;
        rd_active_o <= 1'b0;
      end else if (op_fire) begin
        got_q       <= 1'b1;
        pend_q      <= clr_req_i ? '0 : new_upd;
        rd_active_o <= hit_any;
        rd_sel_o    <= hit_idx;
      end else if (clr_req_i) begin
        pend_q <= '0;
      end
    end
  end

  assign commit_o = end_evt;
  assign upd_o    = clr_req_i ? '0 : pend_q;

  // R2
  one_op_per_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_fire |=> !op_ready_o);
  // R7
  read_needs_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_q |-> !rd_active_o);
endmodule

// File: rtl/fse_status_reg.sv
module fse_status_reg
  import fse_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_wr_i,
  input  logic [W-1:0] sw_wdata_i,
  input  logic         sw_clr_busy_i,
  input  logic         commit_i,
  input  fse_upd_t     upd_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = status_o;
    if (sw_wr_i) nxt = sw_wdata_i;
    if (sw_clr_busy_i) begin
      nxt[BUSY_BIT] = 1'b0;
      nxt[WEL_BIT]  = 1'b0;
    end
    if (commit_i) begin
      if (upd_i.wel_set)       nxt[WEL_BIT] = 1'b1;
      else if (upd_i.wel_clr)  nxt[WEL_BIT] = 1'b0;
      if (upd_i.busy_set)      nxt[BUSY_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= nxt;
  end

  // R6
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_wr_i && !sw_clr_busy_i && !commit_i |=> $stable(status_o));
  // R3
  wel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && upd_i.wel_set |=> status_o[WEL_BIT]);
  // R5
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && upd_i.busy_set |=> status_o[BUSY_BIT]);
  // R10
  sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_busy_i && !(commit_i && upd_i.busy_set) |=> !status_o[BUSY_BIT]);
endmodule

// File: rtl/fse_read_mux.sv
module fse_read_mux #(
  parameter int unsigned NB   = 3,
  parameter int unsigned BW   = 8,
  parameter int unsigned SELW = 2,
  localparam int unsigned W   = NB * BW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    status_i,
  input  logic            active_i,
  input  logic            cs_active_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            rd_ready_i,
  output logic            rd_valid_o,
  output logic [BW-1:0]   rd_data_o
);
  logic [W-1:0]  shifted;
  logic [BW-1:0] hold_q;
  logic          held_q;

  assign shifted    = status_i >> (sel_i * BW);
  assign rd_valid_o = active_i & cs_active_i;
  assign rd_data_o  = held_q ? hold_q : shifted[BW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      hold_q <= '0;
    end else if (rd_valid_o && !rd_ready_i) begin
      held_q <= 1'b1;
      hold_q <= rd_data_o;
    end else begin
      held_q <= 1'b0;
    end
  end

  // R8
  stall_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> !rd_valid_o || $stable(rd_data_o));
  // R7
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (32'(sel_i) < NB));
endmodule

// File: rtl/flash_status_emu.sv
module flash_status_emu
  import fse_pkg::*;
#(
  parameter int unsigned NB  = 3,
  parameter int unsigned BW  = 8,
  parameter logic [NB*BW-1:0] RD_OPS = 24'h153505,
  localparam int unsigned W    = NB * BW,
  localparam int unsigned SELW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_active_i,
  input  logic          op_valid_i,
  output logic          op_ready_o,
  input  logic [BW-1:0] op_i,
  input  logic          op_busy_i,
  input  logic          wren_en_i,
  input  logic [BW-1:0] wren_op_i,
  input  logic          wrdi_en_i,
  input  logic [BW-1:0] wrdi_op_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [BW-1:0] rd_data_o,
  input  logic          sw_wr_i,
  input  logic [W-1:0]  sw_wdata_i,
  input  logic          sw_clr_busy_i,
  input  logic          sw_clr_req_i,
  output logic [W-1:0]  status_o
);
  logic            commit, rd_active;
  logic [SELW-1:0] rd_sel;
  fse_upd_t        upd;

  fse_cmd_capture #(.NB(NB), .OPW(BW), .SELW(SELW), .RD_OPS(RD_OPS)) u_cap (
    .clk_i, .rst_ni, .cs_active_i, .op_valid_i, .op_ready_o, .op_i,
    .busy_attr_i(op_busy_i), .wren_en_i, .wren_op_i, .wrdi_en_i, .wrdi_op_i,
    .clr_req_i(sw_clr_req_i), .commit_o(commit), .upd_o(upd),
    .rd_active_o(rd_active), .rd_sel_o(rd_sel)
  );

  fse_status_reg #(.W(W)) u_reg (
    .clk_i, .rst_ni, .sw_wr_i, .sw_wdata_i, .sw_clr_busy_i,
    .commit_i(commit), .upd_i(upd), .status_o
  );

  fse_read_mux #(.NB(NB), .BW(BW), .SELW(SELW)) u_rd (
    .clk_i, .rst_ni, .status_i(status_o), .active_i(rd_active), .cs_active_i,
    .sel_i(rd_sel), .rd_ready_i, .rd_valid_o, .rd_data_o
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active_i |-> !op_ready_o && !rd_valid_o);
endmodule

// File: tb/sim_flash_status_emu.sv
`timescale 1ns/1ps
module sim_flash_status_emu;
  logic clk = 0, rst_n = 0;
  logic cs = 0, op_valid = 0, op_ready, op_busy = 0;
  logic [7:0] op = 0, wren_op = 8'h06, wrdi_op = 8'h04;
  logic wren_en = 1, wrdi_en = 1;
  logic rd_valid, rd_ready = 1;
  logic [7:0] rd_data;
  logic sw_wr = 0, sw_clr_busy = 0, sw_clr_req = 0;
  logic [23:0] sw_wdata = 0, status;
  logic [23:0] exp_st = 0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_status_emu u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_active_i(cs), .op_valid_i(op_valid),
    .op_ready_o(op_ready), .op_i(op), .op_busy_i(op_busy), .wren_en_i(wren_en),
    .wren_op_i(wren_op), .wrdi_en_i(wrdi_en), .wrdi_op_i(wrdi_op),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata), .sw_clr_busy_i(sw_clr_busy),
    .sw_clr_req_i(sw_clr_req), .status_o(status));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int rd_index(logic [7:0] o);
    if (o == 8'h05) return 0;
    if (o == 8'h35) return 1;
    if (o == 8'h15) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] byte_of(logic [23:0] s, int i);
    return s[i*8 +: 8];
  endfunction

  // Expected status after one edge, from R9, R10, R3, R4, R5, R12
  function automatic logic [23:0] model(logic [23:0] s, bit wr, logic [23:0] wd,
      bit clr, bit commit, bit ws, bit wc, bit bs);
    logic [23:0] r = s;
    if (wr) r = wd;
    if (clr) r[1:0] = 2'b00;
    if (commit) begin
      if (ws) r[1] = 1'b1;
      else if (wc) r[1] = 1'b0;
      if (bs) r[0] = 1'b1;
    end
    return r;
  endfunction

  task automatic sw_op(bit wr, logic [23:0] wd, bit clr, bit creq, string tag);
    @(negedge clk);
    sw_wr = wr; sw_wdata = wd; sw_clr_busy = clr; sw_clr_req = creq;
    @(negedge clk);
    sw_wr = 0; sw_clr_busy = 0; sw_clr_req = 0;
    exp_st = model(exp_st, wr, wd, clr, 0, 0, 0, 0);
    chk(tag, status, exp_st);
  endtask

  // drop: 0 none, 1 discard mid-transaction, 2 discard on closing edge
  task automatic txn(logic [7:0] o, bit busy, int beats, bit stall, int drop,
      bit cwr, logic [23:0] cwd, bit cclr, string tag);
    bit ws, wc, bs;
    int idx;
    logic [23:0] nv;
    @(negedge clk);
    cs = 1; op_valid = 1; op = o; op_busy = busy;
    #0.5 chk("R2 ready before accept", op_ready, 1);
    @(negedge clk);
    op_valid = 0; op_busy = 0;
    chk("R2 ready after accept", op_ready, 0);
    idx = rd_index(o);
    chk("R7 read valid", rd_valid, idx >= 0);
    ws = wren_en && o == wren_op;
    wc = !ws && wrdi_en && o == wrdi_op;
    bs = busy;
    for (int b = 0; b < beats; b++) begin
      rd_ready = $urandom_range(0, 1);
      if (idx >= 0) chk("R7 read byte", rd_data, byte_of(exp_st, idx));
      @(negedge clk);
    end
    rd_ready = 1;
    if (stall && idx >= 0) begin
      rd_ready = 0;
      @(negedge clk);
      nv = $urandom;
      sw_wr = 1; sw_wdata = nv;
      @(negedge clk);
      sw_wr = 0;
      chk("R8 held byte", rd_data, byte_of(exp_st, idx));
      exp_st = nv;
      chk("R9 write during stall", status, exp_st);
      rd_ready = 1;
      @(negedge clk);
      chk("R8 byte after release", rd_data, byte_of(exp_st, idx));
    end
    if (drop == 1) begin
      sw_clr_req = 1;
      @(negedge clk);
      sw_clr_req = 0;
      ws = 0; wc = 0; bs = 0;
    end
    chk("R6 no mid change", status, exp_st);
    cs = 0; sw_wr = cwr; sw_wdata = cwd; sw_clr_busy = cclr;
    sw_clr_req = (drop == 2);
    if (drop == 2) begin ws = 0; wc = 0; bs = 0; end
    @(negedge clk);
    sw_wr = 0; sw_clr_busy = 0; sw_clr_req = 0;
    exp_st = model(exp_st, cwr, cwd, cclr, 1, ws, wc, bs);
    chk(tag, status, exp_st);
    chk("R7 read ends", rd_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 op_ready", op_ready, 0);
    chk("R1 rd_valid", rd_valid, 0);

    txn(8'h06, 0, 1, 0, 0, 0, 0, 0, "R3 wren sets latch");
    txn(8'h04, 0, 1, 0, 0, 0, 0, 0, "R4 wrdi clears latch");
    wren_en = 0;
    txn(8'h06, 0, 1, 0, 0, 0, 0, 0, "R3 disabled wren ignored");
    wren_en = 1;
    txn(8'h02, 1, 2, 0, 0, 0, 0, 0, "R5 busy attribute");
    txn(8'h06, 0, 0, 0, 0, 0, 0, 0, "R3 wren again");
    sw_op(0, 0, 1, 0, "R10 clear busy and latch");
    sw_op(1, 24'hA1B2C3, 0, 0, "R9 software write");
    txn(8'h05, 0, 3, 1, 0, 0, 0, 0, "R7 byte0 read end");
    txn(8'h35, 0, 3, 1, 0, 0, 0, 0, "R7 byte1 read end");
    txn(8'h15, 0, 3, 1, 0, 0, 0, 0, "R7 byte2 read end");
    txn(8'h9F, 0, 2, 0, 0, 0, 0, 0, "R7 other opcode");
    txn(8'h06, 1, 1, 0, 1, 0, 0, 0, "R11 discard mid");
    txn(8'h06, 1, 1, 0, 2, 0, 0, 0, "R11 discard at end");
    sw_op(0, 0, 0, 1, "R11 discard idle");
    txn(8'h06, 1, 1, 0, 0, 1, 24'h000000, 0, "R12 set beats write");
    txn(8'h02, 1, 0, 0, 0, 0, 0, 1, "R12 busy beats clear");
    txn(8'h04, 0, 0, 0, 0, 1, 24'hFFFFFF, 0, "R12 wrdi beats write");
    wrdi_op = 8'h06;
    txn(8'h06, 0, 0, 0, 0, 1, 24'h000000, 0, "R4 set wins");
    wrdi_op = 8'h04;

    for (int n = 0; n < 120; n++) begin
      logic [7:0] o;
      int k = $urandom_range(0, 6);
      case (k)
        0: o = wren_op; 1: o = wrdi_op; 2: o = 8'h05; 3: o = 8'h35;
        4: o = 8'h15; default: o = $urandom;
      endcase
      if ($urandom_range(0, 9) == 0) wren_en = ~wren_en;
      if ($urandom_range(0, 9) == 0) wrdi_en = ~wrdi_en;
      txn(o, $urandom_range(0, 3) == 0, $urandom_range(0, 3),
          $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0 ? 1 : 0,
          $urandom_range(0, 4) == 0, $urandom, $urandom_range(0, 4) == 0,
          "R3 R4 R5 R12 random end");
      if ($urandom_range(0, 3) == 0)
        sw_op($urandom_range(0, 1), $urandom, $urandom_range(0, 1), 0,
              "R9 R10 random software");
    end
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule